// File: doc/BRIEF.md
# IDE Channel Address Decoder

This block sits between a host I/O port bus and the two channels of an IDE controller. Every cycle it looks at one host access (address, size, direction, write data) and decides which channel register window it falls in. It then raises exactly one strobe: a task-file register select, a data-port transfer or a control-register select. When the access breaks the per-offset size rules, it raises none. Reads come back one cycle later with a valid pulse. A read that lands in a window but is refused returns all ones at the access width.

The decoder holds a mode bit that comes from the low nibble of a programming-interface byte written by software. In legacy mode two sets of fixed port windows are live. In native mode the fixed windows go quiet and only the relocatable windows respond, whose bases come from the base-register inputs. The relocatable windows respond in both modes. The mode bit also sets the reported interrupt-pin value. The drives themselves and the programming of the base registers live outside this block.

Top module: `ide_chan_decode`

## Requirements
- R1: After reset the block is in legacy mode, `irq_pin` is 0, no strobe is raised and `rd_valid` is low.
- R2: A config write whose low nibble is 0xA selects legacy mode and sets `irq_pin` to 0. In legacy mode channel 0 answers at command window 0x1F0-0x1F7 and control window 0x3F4-0x3F7, and channel 1 answers at 0x170-0x177 and 0x374-0x377.
- R3: A config write whose low nibble is 0xF selects native mode and sets `irq_pin` to 1. In native mode the fixed windows raise no strobe and produce no `rd_valid`.
- R4: A config write with any other low nibble leaves the mode and `irq_pin` unchanged.
- R5: A config write changes the decoding from the next cycle onward. An access in the same cycle as the write still uses the old mode.
- R6: Relocatable windows are decoded in both modes: an 8-byte command window at `bar_cmd[c]` with bits [2:0] ignored, and a 4-byte control window at `bar_ctl[c]` with bits [1:0] ignored. On overlap, a fixed window wins over a relocatable one, a lower channel wins over a higher one, and command wins over control. At most one strobe is raised per cycle.
- R7: In a control window, a byte access at offset 2 raises `ctl_stb` for that channel. A read there returns the channel's read byte, zero-extended.
- R8: Any other control-window access raises no strobe. A read returns all ones at the access width: 0xFF, 0xFFFF or 0xFFFFFFFF.
- R9: In a command window, a byte access raises `tf_stb` for the channel with `tf_reg` equal to the offset (0-7). A read returns the channel's read byte, zero-extended.
- R10: In a command window, a 16-bit or 32-bit access at offset 0 raises `dp_stb`, with `dp_wide` high only for 32 bits. A read returns the channel data masked to the width.
- R11: In a command window, a 16-bit or 32-bit access at a nonzero offset raises no strobe, and a read returns all ones at the width.
- R12: `acc_size` encodes byte=0, 16-bit=1, 32-bit=2. A read that hits any window gives `rd_valid` high for exactly the following cycle, with `rd_data` holding the result. Writes and misses give no `rd_valid`.
- R13: `bus_we` equals `acc_valid && acc_write`. `bus_wdata` is `acc_wdata` with the bytes beyond the access width cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the programming-interface byte |
| cfg_wdata | input | 8 | Programming-interface byte; the low nibble selects the mode |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Host I/O address |
| acc_size | input | 2 | Access width code |
| acc_wdata | input | 32 | Host write data |
| bar_cmd | input | NUM_CH*ADDR_W | Relocatable command-window bases, channel 0 in the low slice |
| bar_ctl | input | NUM_CH*ADDR_W | Relocatable control-window bases |
| chan_rdata | input | NUM_CH*32 | Per-channel read data returned in the strobe cycle |
| irq_pin | output | 8 | Reported interrupt-pin value |
| tf_stb | output | NUM_CH | Task-file register select per channel |
| tf_reg | output | 3 | Task-file register offset |
| dp_stb | output | NUM_CH | Data-port transfer per channel |
| dp_wide | output | 1 | Data-port transfer is 32-bit |
| ctl_stb | output | NUM_CH | Alternate-status read / device-control write per channel |
| bus_we | output | 1 | Write qualifier for the strobes |
| bus_wdata | output | 32 | Write data masked to the access width |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |

## Verification
The assertions assume that `acc_size` never carries the unused code 3. They also assume that the channel read data is stable during the cycle its strobe is raised. The stimulus drives only the three defined width codes and holds `chan_rdata` at fixed per-channel patterns. Relocatable bases change only between accesses, never in the middle of one. The bench overlaps a relocatable window with a fixed window on purpose, so that it exercises the priority rule while the checks stay deterministic.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;

  localparam int DW = 32;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam logic [3:0] NIB_LEGACY = 4'hA;
  localparam logic [3:0] NIB_NATIVE = 4'hF;

  typedef enum logic [1:0] {
    K_NONE = 2'd0,
    K_TASK = 2'd1,
    K_DATA = 2'd2,
    K_CTRL = 2'd3
  } acc_kind_e;

  // all-ones pattern for an access width code
  function automatic logic [DW-1:0] width_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [15:0] legacy_cmd_base(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

  function automatic logic [15:0] legacy_ctl_base(input int ch);
    return (ch == 0) ? 16'h03F4 : 16'h0374;
  endfunction

  // per-offset size rules inside a selected window
  function automatic acc_kind_e classify(input logic is_ctl, input logic [2:0] off,
                                         input logic [1:0] sz);
    if (is_ctl) begin
      return (sz == SZ_BYTE && off == 3'd2) ? K_CTRL : K_NONE;
    end
    if (sz == SZ_BYTE) return K_TASK;
    return (off == 3'd0) ? K_DATA : K_NONE;
  endfunction

endpackage

// File: rtl/ide_mode_reg.sv
module ide_mode_reg #(
  parameter logic RST_NATIVE = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_nib,
  output logic       native,
  output logic [7:0] irq_pin,
  output logic       mode_upd
);
  import ide_dec_pkg::*;

  assign mode_upd = cfg_we && (cfg_nib == NIB_LEGACY || cfg_nib == NIB_NATIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      native <= RST_NATIVE;
    end else if (mode_upd) begin
      native <= (cfg_nib == NIB_NATIVE);
    end
  end

  assign irq_pin = {7'd0, native};

endmodule

// File: rtl/ide_win_match.sv
module ide_win_match #(
  parameter int ADDR_W    = 16,
  parameter int SPAN_LOG2 = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              en,
  output logic              hit
);
  logic unused_low;
  assign unused_low = ^{addr[SPAN_LOG2-1:0], base[SPAN_LOG2-1:0]};

  assign hit = en && (addr[ADDR_W-1:SPAN_LOG2] == base[ADDR_W-1:SPAN_LOG2]);

endmodule

// File: rtl/ide_win_select.sv
module ide_win_select #(
  parameter int NUM_CH = 2,
  parameter int CH_W   = 1
) (
  input  logic [NUM_CH-1:0] leg_cmd,
  input  logic [NUM_CH-1:0] leg_ctl,
  input  logic [NUM_CH-1:0] bar_cmd,
  input  logic [NUM_CH-1:0] bar_ctl,
  output logic              sel_valid,
  output logic [CH_W-1:0]   sel_ch,
  output logic              sel_ctl
);
  // lowest priority assigned first; later assignments win
  always_comb begin
    sel_valid = 1'b0;
    sel_ch    = '0;
    sel_ctl   = 1'b0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (bar_ctl[c]) begin
        sel_valid = 1'b1; sel_ch = CH_W'(c); sel_ctl = 1'b1;
      end
      if (bar_cmd[c]) begin
        sel_valid = 1'b1; sel_ch = CH_W'(c); sel_ctl = 1'b0;
      end
    end
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (leg_ctl[c]) begin
        sel_valid = 1'b1; sel_ch = CH_W'(c); sel_ctl = 1'b1;
      end
      if (leg_cmd[c]) begin
        sel_valid = 1'b1; sel_ch = CH_W'(c); sel_ctl = 1'b0;
      end
    end
  end

endmodule

// File: rtl/ide_rd_stage.sv
module ide_rd_stage #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [DW-1:0] rd_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_in;
    end
  end

endmodule

// File: rtl/ide_chan_decode.sv
module ide_chan_decode #(
  parameter int   NUM_CH     = 2,
  parameter int   ADDR_W     = 16,
  parameter logic RST_NATIVE = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [7:0]               cfg_wdata,
  input  logic                     acc_valid,
  input  logic                     acc_write,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [1:0]               acc_size,
  input  logic [31:0]              acc_wdata,
  input  logic [NUM_CH*ADDR_W-1:0] bar_cmd,
  input  logic [NUM_CH*ADDR_W-1:0] bar_ctl,
  input  logic [NUM_CH*32-1:0]     chan_rdata,
  output logic [7:0]               irq_pin,
  output logic [NUM_CH-1:0]        tf_stb,
  output logic [2:0]               tf_reg,
  output logic [NUM_CH-1:0]        dp_stb,
  output logic                     dp_wide,
  output logic [NUM_CH-1:0]        ctl_stb,
  output logic                     bus_we,
  output logic [31:0]              bus_wdata,
  output logic                     rd_valid,
  output logic [31:0]              rd_data
);
  import ide_dec_pkg::*;

  localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CMD_SPAN = 3;
  localparam int CTL_SPAN = 2;
  localparam int LEG_CH   = 2;

  logic              native;
  logic              mode_upd;
  logic [NUM_CH-1:0] leg_cmd_hit, leg_ctl_hit, bar_cmd_hit, bar_ctl_hit;
  logic              sel_valid, sel_ctl;
  logic [CH_W-1:0]   sel_ch;
  logic              acc_hit;
  logic [2:0]        acc_off;
  acc_kind_e         kind;
  logic [NUM_CH-1:0] ch_onehot;
  logic [31:0]       acc_mask;
  logic [31:0]       chan_sel_data;
  logic [31:0]       rd_in;
  logic              rd_en;
  logic              unused_cfg;

  assign unused_cfg = ^{cfg_wdata[7:4], mode_upd};

  ide_mode_reg #(.RST_NATIVE(RST_NATIVE)) u_mode (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_nib(cfg_wdata[3:0]),
    .native(native), .irq_pin(irq_pin), .mode_upd(mode_upd)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic HAS_LEG = (c < LEG_CH);

    ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(CMD_SPAN)) u_lcmd (
      .addr(acc_addr), .base(ADDR_W'(legacy_cmd_base(c))),
      .en(HAS_LEG && !native), .hit(leg_cmd_hit[c])
    );
    ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(CTL_SPAN)) u_lctl (
      .addr(acc_addr), .base(ADDR_W'(legacy_ctl_base(c))),
      .en(HAS_LEG && !native), .hit(leg_ctl_hit[c])
    );
    ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(CMD_SPAN)) u_bcmd (
      .addr(acc_addr), .base(bar_cmd[c*ADDR_W +: ADDR_W]),
      .en(1'b1), .hit(bar_cmd_hit[c])
    );
    ide_win_match #(.ADDR_W(ADDR_W), .SPAN_LOG2(CTL_SPAN)) u_bctl (
      .addr(acc_addr), .base(bar_ctl[c*ADDR_W +: ADDR_W]),
      .en(1'b1), .hit(bar_ctl_hit[c])
    );
  end

  ide_win_select #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sel (
    .leg_cmd(leg_cmd_hit), .leg_ctl(leg_ctl_hit),
    .bar_cmd(bar_cmd_hit), .bar_ctl(bar_ctl_hit),
    .sel_valid(sel_valid), .sel_ch(sel_ch), .sel_ctl(sel_ctl)
  );

  assign acc_hit   = acc_valid && sel_valid;
  assign acc_off   = sel_ctl ? 3'(acc_addr[CTL_SPAN-1:0]) : acc_addr[CMD_SPAN-1:0];
  assign kind      = acc_hit ? classify(sel_ctl, acc_off, acc_size) : K_NONE;
  assign ch_onehot = NUM_CH'(1) << sel_ch;
  assign acc_mask  = width_mask(acc_size);

  assign tf_stb  = (kind == K_TASK) ? ch_onehot : '0;
  assign dp_stb  = (kind == K_DATA) ? ch_onehot : '0;
  assign ctl_stb = (kind == K_CTRL) ? ch_onehot : '0;
  assign tf_reg  = acc_addr[2:0];
  assign dp_wide = (acc_size == SZ_WORD);

  assign bus_we    = acc_valid && acc_write;
  assign bus_wdata = acc_wdata & acc_mask;

  assign chan_sel_data = chan_rdata[int'(sel_ch)*DW +: DW];
  assign rd_in = (kind == K_NONE) ? acc_mask : (chan_sel_data & acc_mask);
  assign rd_en = acc_hit && !acc_write;

  ide_rd_stage #(.DW(DW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_in(rd_in),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

endmodule

// File: rtl/ide_chan_decode_chk.sv
module ide_chan_decode_chk #(
  parameter int NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [3:0]        cfg_nib,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [2:0]        acc_low,
  input logic [1:0]        acc_size,
  input logic              acc_hit,
  input logic [NUM_CH-1:0] tf_stb,
  input logic [NUM_CH-1:0] dp_stb,
  input logic [NUM_CH-1:0] ctl_stb,
  input logic [7:0]        irq_pin,
  input logic              rd_valid
);

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tf_stb, dp_stb, ctl_stb}));

  assert_legacy_irq_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_nib == 4'hA) |=> (irq_pin == 8'd0));

  assert_native_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_nib == 4'hF) |=> (irq_pin == 8'd1));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we || (cfg_nib != 4'hA && cfg_nib != 4'hF)) |=> $stable(irq_pin));

  assert_ctl_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_stb) |-> (acc_size == 2'd0 && acc_low[1:0] == 2'd2));

  assert_dp_offset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|dp_stb) |-> (acc_size != 2'd0 && acc_low == 3'd0));

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_hit) |=> rd_valid);

  assert_rd_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && !acc_write && acc_hit) |=> !rd_valid);

endmodule

bind ide_chan_decode ide_chan_decode_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_nib(cfg_wdata[3:0]),
  .acc_valid(acc_valid), .acc_write(acc_write), .acc_low(acc_addr[2:0]),
  .acc_size(acc_size), .acc_hit(acc_hit), .tf_stb(tf_stb), .dp_stb(dp_stb),
  .ctl_stb(ctl_stb), .irq_pin(irq_pin), .rd_valid(rd_valid)
);

// File: tb/ide_chan_decode_test.sv
`timescale 1ns/1ps
module ide_chan_decode_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_wdata = 8'h00;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [15:0] acc_addr = 16'h0;
  logic [1:0]  acc_size = 2'd0;
  logic [31:0] acc_wdata = 32'h0;
  logic [15:0] b_cmd [2];
  logic [15:0] b_ctl [2];
  logic [31:0] bar_cmd, bar_ctl;
  logic [63:0] chan_rdata;
  logic [7:0]  irq_pin;
  logic [1:0]  tf_stb, dp_stb, ctl_stb;
  logic [2:0]  tf_reg;
  logic        dp_wide, bus_we, rd_valid;
  logic [31:0] bus_wdata, rd_data;

  localparam logic [31:0] CH0_DATA = 32'hA1B2_C3D4;
  localparam logic [31:0] CH1_DATA = 32'h5E6F_7081;

  assign bar_cmd    = {b_cmd[1], b_cmd[0]};
  assign bar_ctl    = {b_ctl[1], b_ctl[0]};
  assign chan_rdata = {CH1_DATA, CH0_DATA};

  always #4 clk = ~clk;

  ide_chan_decode uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_wdata(acc_wdata), .bar_cmd(bar_cmd),
    .bar_ctl(bar_ctl), .chan_rdata(chan_rdata), .irq_pin(irq_pin),
    .tf_stb(tf_stb), .tf_reg(tf_reg), .dp_stb(dp_stb), .dp_wide(dp_wide),
    .ctl_stb(ctl_stb), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  int    m_native = 0;
  bit    p_rd = 0;
  logic [31:0] p_data = 32'h0;
  string p_tag = "R1";

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // one bus cycle: drive, then compare against the behavioural model
  task automatic step(string tag, bit v, bit w, int addr, int sz, logic [31:0] wd,
                      bit cwe = 0, int cval = 0);
    int base [8];
    int span [8];
    int chn  [8];
    bit isctl[8];
    bit on   [8];
    int hit_k, lo, off, kind, ch;
    logic [31:0] mask, e_data;
    bit e_rd;
    @(posedge clk); #1;
    acc_valid = v; acc_write = w; acc_addr = 16'(addr); acc_size = 2'(sz);
    acc_wdata = wd; cfg_we = cwe; cfg_wdata = 8'(cval);
    @(negedge clk);
    base  = '{'h1F0, 'h3F4, 'h170, 'h374,
              int'(b_cmd[0]), int'(b_ctl[0]), int'(b_cmd[1]), int'(b_ctl[1])};
    span  = '{8, 4, 8, 4, 8, 4, 8, 4};
    chn   = '{0, 0, 1, 1, 0, 0, 1, 1};
    isctl = '{0, 1, 0, 1, 0, 1, 0, 1};
    for (int k = 0; k < 8; k++) on[k] = (k >= 4) || (m_native == 0);
    hit_k = -1; off = 0;
    if (v) begin
      for (int k = 0; k < 8; k++) begin
        lo = base[k] - (base[k] % span[k]);
        if (hit_k < 0 && on[k] && addr >= lo && addr < lo + span[k]) begin
          hit_k = k; off = addr - lo;
        end
      end
    end
    mask = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
    kind = 0; ch = 0;
    if (hit_k >= 0) begin
      ch = chn[hit_k];
      if (isctl[hit_k]) kind = (sz == 0 && off == 2) ? 3 : 0;
      else if (sz == 0) kind = 1;
      else kind = (off == 0) ? 2 : 0;
    end
    e_rd   = (hit_k >= 0) && !w;
    e_data = (kind == 0) ? mask : (((ch == 0) ? CH0_DATA : CH1_DATA) & mask);

    chk(tag, "tf_stb",  32'(tf_stb),  (kind == 1) ? (32'd1 << ch) : 32'd0);
    chk(tag, "dp_stb",  32'(dp_stb),  (kind == 2) ? (32'd1 << ch) : 32'd0);
    chk(tag, "ctl_stb", 32'(ctl_stb), (kind == 3) ? (32'd1 << ch) : 32'd0);
    if (kind == 1) chk(tag, "tf_reg", 32'(tf_reg), 32'(off));
    if (kind == 2) chk(tag, "dp_wide", 32'(dp_wide), 32'(sz == 2));
    chk(tag, "irq_pin", 32'(irq_pin), 32'(m_native));
    if (v) begin
      chk({tag, "/R13"}, "bus_we", 32'(bus_we), 32'(w));
      chk({tag, "/R13"}, "bus_wdata", bus_wdata, wd & mask);
    end
    chk({p_tag, "/R12"}, "rd_valid", 32'(rd_valid), 32'(p_rd));
    if (p_rd) chk(p_tag, "rd_data", rd_data, p_data);

    p_rd = e_rd; p_data = e_data; p_tag = tag;
    if (cwe && (cval & 'hF) == 'hA) m_native = 0;
    if (cwe && (cval & 'hF) == 'hF) m_native = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    b_cmd[0] = 16'hC000; b_ctl[0] = 16'hC010;
    b_cmd[1] = 16'hC020; b_ctl[1] = 16'hC030;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "irq_pin in reset", 32'(irq_pin), 32'd0);
    chk("R1", "rd_valid in reset", 32'(rd_valid), 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    step("R1", 0, 0, 0, 0, 0);
    // legacy fixed windows, command side
    step("R9",  1, 0, 'h1F3, 0, 0);
    step("R9",  1, 1, 'h177, 0, 32'h1234_56AB);
    step("R10", 1, 0, 'h1F0, 1, 0);
    step("R10", 1, 1, 'h170, 2, 32'hDEAD_BEEF);
    step("R11", 1, 0, 'h1F2, 1, 0);
    step("R11", 1, 1, 'h172, 2, 32'h0BAD_F00D);
    step("R11", 1, 0, 'h176, 2, 0);
    // legacy control windows
    step("R7", 1, 0, 'h3F6, 0, 0);
    step("R7", 1, 1, 'h376, 0, 32'h0000_0004);
    step("R8", 1, 0, 'h3F4, 0, 0);
    step("R8", 1, 0, 'h3F6, 1, 0);
    step("R8", 1, 1, 'h3F6, 2, 32'hFFFF_0002);
    step("R8", 1, 0, 'h377, 2, 0);
    step("R12", 1, 0, 'h0100, 0, 0);
    // relocatable windows while legacy
    step("R6", 1, 0, 'hC001, 0, 0);
    step("R6", 1, 0, 'hC032, 0, 0);
    step("R6", 1, 0, 'hC024, 0, 0);
    step("R2", 0, 0, 0, 0, 0);
    // other nibble: no change
    step("R4", 1, 0, 'h1F1, 0, 0, 1, 'h05);
    step("R4", 1, 0, 'h1F1, 0, 0, 1, 'hF0);
    step("R4", 1, 0, 'h3F6, 0, 0);
    // switch to native, same-cycle access still legacy
    step("R5", 1, 0, 'h1F4, 0, 0, 1, 'h8F);
    step("R3", 1, 0, 'h1F4, 0, 0);
    step("R3", 1, 0, 'h3F6, 0, 0);
    step("R3", 1, 1, 'h170, 1, 32'h0000_5555);
    step("R6", 1, 0, 'hC020, 2, 0);
    step("R10", 1, 0, 'hC000, 1, 0);
    step("R12", 1, 0, 'hC011, 2, 0);
    step("R7", 1, 0, 'hC012, 0, 0);
    // overlap a relocatable window with a fixed one
    step("R6", 0, 0, 0, 0, 0);
    b_cmd[1] = 16'h01F0;
    step("R6", 1, 0, 'h1F5, 0, 0);
    step("R5", 1, 0, 'h1F0, 0, 0, 1, 'h8A);
    step("R6", 1, 0, 'h1F0, 0, 0);
    step("R2", 1, 0, 'h1F0, 1, 0);
    step("R4", 1, 0, 'h1F0, 0, 0, 1, 'h00);
    step("R2", 1, 1, 'h1F0, 0, 32'h0000_0077);
    step("R12", 0, 0, 0, 0, 0);
    step("R12", 0, 0, 0, 0, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule